// File: doc/BRIEF.md
# Bitmask Power-Rail Programming Sequencer

This block writes power-net bitmasks into an external chain of daisy-chained serial shift registers, one 16-bit slice per board. A single controller enable drives the whole sequence. When enable rises, the block first programs a mask that switches on the gate-driver supply. It then waits for a programmable settling delay and programs a second mask that switches on every net. When enable falls, it programs a mask that switches off everything except the always-on net group. An abort input returns both internal engines to idle at once, from any state.

Inside, a sequencer picks one of the three masks from the current phase and from its delay-timer status. It holds the chosen word in an output buffer and starts a serial shifter through a start/valid/acknowledge handshake. The shifter sends the word most significant bit first. It drives a shift clock whose high and low phases each last one system clock cycle, and it ends the transfer with a single-cycle latch strobe.

Within each board slice, positions 0 to 2 are unused, position 3 is the gate-driver supply, and positions 4 to 15 are the twelve switched nets of the four devices. The block does not interpret these bits. It carries them from the mask inputs to the chain without changing them.

Top module: `rail_prog_top`

## Requirements
- R1: While reset is held, and after reset until enable changes, the shift clock, serial data and latch outputs are low, and no latch strobe occurs.
- R2: A rising edge of enable latches the gate-driver mask into the chain, then the all-nets mask. Mask bit i ends up at chain position i, and the first bit sent (bit CHAIN_W-1) sits at the far end of the chain, in the last board's slice.
- R3: The first shift-clock rise of the all-nets transfer comes exactly dly_start+6 clock cycles after the latch strobe of the gate-driver transfer.
- R4: A falling edge of enable while the block is idle latches the off mask with exactly one latch strobe, after which the block is idle.
- R5: A falling edge of enable during the gate-driver transfer or during the delay replaces the all-nets transfer with the off mask, giving exactly two latch strobes (gate-driver mask, then off mask).
- R6: A rising edge of enable while a sequence is in progress is ignored and starts no further transfer.
- R7: Abort stops the transfer in progress: one cycle later the shift clock and latch are low, and no latch strobe occurs for the aborted sequence.
- R8: Every transfer gives exactly CHAIN_W shift-clock rises. Each clock high lasts one cycle, and serial data does not change while the clock is high.
- R9: The latch strobe is one cycle wide, follows the last clock-high cycle with the clock low, and never coincides with the shift clock.
- R10: A new rising edge of enable after a completed sequence clears the delay-done state, so the gate-driver transfer and the delay run again before the all-nets transfer.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ctrl_en | input | 1 | Controller enable; rising and falling edges start sequences |
| abort | input | 1 | Returns sequencer and shifter to idle at once |
| mask_drv | input | CHAIN_W | Mask programmed first: gate-driver supply on |
| mask_all | input | CHAIN_W | Mask programmed after the delay: all nets on |
| mask_off | input | CHAIN_W | Mask programmed on a falling enable edge |
| dly_start | input | DLY_W | Start value of the settling-delay down-counter |
| sr_data | output | 1 | Serial data to the chain, MSB first |
| sr_clk | output | 1 | Shift clock to the chain |
| sr_latch | output | 1 | Latch strobe that makes the chain contents active |

## Verification
The bench builds the block with two boards (a 32-bit chain) and a 6-bit delay value. The short chain keeps each transfer near 70 cycles, so dozens of complete enable cycles fit in the run. The narrow delay field makes both ends of the delay range, 0 and 63, reachable, and the D+6 spacing is checked at each of them. Each latched word is rebuilt from the serial pins by a model of the external chain.

// File: rtl/rail_prog_pkg.sv
package rail_prog_pkg;

    typedef enum logic [2:0] {
        SQ_IDLE,
        SQ_LOAD,
        SQ_INIT,
        SQ_WAIT,
        SQ_DELAY
    } seq_state_e;

    typedef enum logic [2:0] {
        SH_IDLE,
        SH_LOAD,
        SH_CLK_LO,
        SH_CLK_HI,
        SH_LATCH
    } shf_state_e;

    typedef enum logic [1:0] {
        MSK_DRV,
        MSK_ALL,
        MSK_OFF
    } mask_sel_e;

endpackage

// File: rtl/rail_edge_detect.sv
module rail_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic level,
    output logic rise,
    output logic fall
);
    logic lvl_d, lvl_q;

    always_comb begin
        lvl_d = level;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lvl_q <= 1'b0;
        else        lvl_q <= lvl_d;
    end

    assign rise = level & ~lvl_q;
    assign fall = ~level & lvl_q;
endmodule

// File: rtl/rail_mask_select.sv
module rail_mask_select
    import rail_prog_pkg::*;
#(
    parameter int CHAIN_W = 64
) (
    input  mask_sel_e          sel,
    input  logic [CHAIN_W-1:0] mask_drv,
    input  logic [CHAIN_W-1:0] mask_all,
    input  logic [CHAIN_W-1:0] mask_off,
    output logic [CHAIN_W-1:0] word
);
    always_comb begin
        unique case (sel)
            MSK_ALL: word = mask_all;
            MSK_OFF: word = mask_off;
            default: word = mask_drv;
        endcase
    end
endmodule

// File: rtl/rail_seq_ctrl.sv
module rail_seq_ctrl
    import rail_prog_pkg::*;
#(
    parameter int CHAIN_W = 64,
    parameter int DLY_W   = 24
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               en_rise,
    input  logic               en_fall,
    input  logic [DLY_W-1:0]   dly_start,
    input  logic [CHAIN_W-1:0] sel_word,
    input  logic               sh_idle,
    input  logic               sh_ack,
    output mask_sel_e          mask_sel,
    output logic [CHAIN_W-1:0] word,
    output logic               sh_start,
    output logic               sh_vld
);
    typedef struct packed {
        seq_state_e         st;
        logic               off_mode;
        logic               pend_off;
        logic               tmr_done;
        logic [DLY_W-1:0]   tmr;
        logic [CHAIN_W-1:0] word;
    } seq_reg_t;

    seq_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (en_fall && r_q.st != SQ_IDLE) r_d.pend_off = 1'b1;

        unique case (r_q.st)
            SQ_IDLE: begin
                if (en_rise) begin
                    r_d.tmr_done = 1'b0;
                    r_d.off_mode = 1'b0;
                    r_d.pend_off = 1'b0;
                    r_d.st       = SQ_LOAD;
                end else if (en_fall) begin
                    r_d.off_mode = 1'b1;
                    r_d.pend_off = 1'b0;
                    r_d.st       = SQ_LOAD;
                end
            end
            SQ_LOAD: begin
                r_d.word = sel_word;
                r_d.st   = SQ_INIT;
            end
            SQ_INIT: begin
                if (sh_idle) r_d.st = SQ_WAIT;
            end
            SQ_WAIT: begin
                if (sh_ack) begin
                    if (r_q.off_mode) begin
                        r_d.off_mode = 1'b0;
                        r_d.pend_off = 1'b0;
                        r_d.st       = SQ_IDLE;
                    end else if (r_q.pend_off || en_fall) begin
                        r_d.off_mode = 1'b1;
                        r_d.pend_off = 1'b0;
                        r_d.st       = SQ_LOAD;
                    end else if (r_q.tmr_done) begin
                        r_d.st = SQ_IDLE;
                    end else begin
                        r_d.tmr = dly_start;
                        r_d.st  = SQ_DELAY;
                    end
                end
            end
            SQ_DELAY: begin
                if (r_q.pend_off || en_fall) begin
                    r_d.off_mode = 1'b1;
                    r_d.pend_off = 1'b0;
                    r_d.st       = SQ_LOAD;
                end else if (r_q.tmr == '0) begin
                    r_d.tmr_done = 1'b1;
                    r_d.st       = SQ_LOAD;
                end else begin
                    r_d.tmr = r_q.tmr - 1'b1;
                end
            end
            default: r_d.st = SQ_IDLE;
        endcase

        if (abort) begin
            r_d.st       = SQ_IDLE;
            r_d.pend_off = 1'b0;
            r_d.off_mode = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st       <= SQ_IDLE;
            r_q.off_mode <= 1'b0;
            r_q.pend_off <= 1'b0;
            r_q.tmr_done <= 1'b0;
            r_q.tmr      <= '0;
            r_q.word     <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign mask_sel = r_q.off_mode ? MSK_OFF : (r_q.tmr_done ? MSK_ALL : MSK_DRV);
    assign word     = r_q.word;
    assign sh_start = (r_q.st == SQ_INIT);
    assign sh_vld   = (r_q.st == SQ_WAIT);
endmodule

// File: rtl/rail_serial_shifter.sv
module rail_serial_shifter
    import rail_prog_pkg::*;
#(
    parameter int CHAIN_W = 64
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               abort,
    input  logic               start,
    input  logic               vld,
    input  logic [CHAIN_W-1:0] word,
    output logic               idle,
    output logic               ack,
    output logic               sr_data,
    output logic               sr_clk,
    output logic               sr_latch
);
    localparam int CNT_W = $clog2(CHAIN_W + 1);
    localparam logic [CNT_W-1:0] CNT_LOAD = CNT_W'(CHAIN_W);

    typedef struct packed {
        shf_state_e         st;
        logic [CNT_W-1:0]   cnt;
        logic [CHAIN_W-1:0] sh;
    } shf_reg_t;

    shf_reg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        unique case (r_q.st)
            SH_IDLE: begin
                if (start) r_d.st = SH_LOAD;
            end
            SH_LOAD: begin
                if (vld) begin
                    r_d.sh  = word;
                    r_d.cnt = CNT_LOAD;
                    r_d.st  = SH_CLK_LO;
                end
            end
            SH_CLK_LO: begin
                if (r_q.cnt == '0) begin
                    r_d.st = SH_LATCH;
                end else begin
                    r_d.cnt = r_q.cnt - 1'b1;
                    r_d.st  = SH_CLK_HI;
                end
            end
            SH_CLK_HI: begin
                r_d.sh = {r_q.sh[CHAIN_W-2:0], 1'b0};
                r_d.st = SH_CLK_LO;
            end
            SH_LATCH: r_d.st = SH_IDLE;
            default:  r_d.st = SH_IDLE;
        endcase
        if (abort) r_d.st = SH_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.st  <= SH_IDLE;
            r_q.cnt <= '0;
            r_q.sh  <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign idle     = (r_q.st == SH_IDLE);
    assign ack      = (r_q.st == SH_LATCH);
    assign sr_data  = r_q.sh[CHAIN_W-1];
    assign sr_clk   = (r_q.st == SH_CLK_HI);
    assign sr_latch = (r_q.st == SH_LATCH);
endmodule

// File: rtl/rail_prog_top.sv
module rail_prog_top
    import rail_prog_pkg::*;
#(
    parameter int NUM_BOARDS     = 4,
    parameter int BITS_PER_BOARD = 16,
    parameter int DLY_W          = 24
) (
    input  logic                                 clk,
    input  logic                                 rst_n,
    input  logic                                 ctrl_en,
    input  logic                                 abort,
    input  logic [NUM_BOARDS*BITS_PER_BOARD-1:0] mask_drv,
    input  logic [NUM_BOARDS*BITS_PER_BOARD-1:0] mask_all,
    input  logic [NUM_BOARDS*BITS_PER_BOARD-1:0] mask_off,
    input  logic [DLY_W-1:0]                     dly_start,
    output logic                                 sr_data,
    output logic                                 sr_clk,
    output logic                                 sr_latch
);
    localparam int CHAIN_W = NUM_BOARDS * BITS_PER_BOARD;

    logic               en_rise, en_fall;
    mask_sel_e          mask_sel;
    logic [CHAIN_W-1:0] sel_word, buf_word;
    logic               sh_start, sh_vld, sh_idle, sh_ack;

    rail_edge_detect u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .level (ctrl_en),
        .rise  (en_rise),
        .fall  (en_fall)
    );

    rail_mask_select #(.CHAIN_W(CHAIN_W)) u_sel (
        .sel      (mask_sel),
        .mask_drv (mask_drv),
        .mask_all (mask_all),
        .mask_off (mask_off),
        .word     (sel_word)
    );

    rail_seq_ctrl #(.CHAIN_W(CHAIN_W), .DLY_W(DLY_W)) u_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .abort     (abort),
        .en_rise   (en_rise),
        .en_fall   (en_fall),
        .dly_start (dly_start),
        .sel_word  (sel_word),
        .sh_idle   (sh_idle),
        .sh_ack    (sh_ack),
        .mask_sel  (mask_sel),
        .word      (buf_word),
        .sh_start  (sh_start),
        .sh_vld    (sh_vld)
    );

    rail_serial_shifter #(.CHAIN_W(CHAIN_W)) u_shf (
        .clk      (clk),
        .rst_n    (rst_n),
        .abort    (abort),
        .start    (sh_start),
        .vld      (sh_vld),
        .word     (buf_word),
        .idle     (sh_idle),
        .ack      (sh_ack),
        .sr_data  (sr_data),
        .sr_clk   (sr_clk),
        .sr_latch (sr_latch)
    );
endmodule

// File: rtl/rail_prog_chk.sv
module rail_prog_chk #(
    parameter int CHAIN_W = 64
) (
    input logic clk,
    input logic rst_n,
    input logic abort,
    input logic sr_data,
    input logic sr_clk,
    input logic sr_latch
);
    localparam int RC_W = $clog2(CHAIN_W + 2) + 1;

    logic [RC_W-1:0] rise_cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                 rise_cnt_q <= '0;
        else if (abort || sr_latch) rise_cnt_q <= '0;
        else if (sr_clk)            rise_cnt_q <= rise_cnt_q + 1'b1;
    end

    p_clk_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_clk |=> !sr_clk);

    p_data_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_clk |-> $stable(sr_data));

    p_bit_count_r8: assert property (@(posedge clk) disable iff (!rst_n)
        sr_latch |-> (rise_cnt_q == RC_W'(CHAIN_W)));

    p_latch_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_latch |=> !sr_latch);

    p_latch_clk_low_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sr_latch |-> (!sr_clk && !$past(sr_clk)));

    p_abort_stops_r7: assert property (@(posedge clk) disable iff (!rst_n)
        abort |=> (!sr_clk && !sr_latch));
endmodule

bind rail_prog_top rail_prog_chk #(.CHAIN_W(CHAIN_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .abort    (abort),
    .sr_data  (sr_data),
    .sr_clk   (sr_clk),
    .sr_latch (sr_latch)
);

// File: tb/tb_rail_prog_top.sv
module tb_rail_prog_top;
    localparam int NB = 2;
    localparam int BPB = 16;
    localparam int DW = 6;
    localparam int W = NB * BPB;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          ctrl_en = 1'b0;
    logic          abort = 1'b0;
    logic [W-1:0]  mask_drv = '0, mask_all = '0, mask_off = '0;
    logic [DW-1:0] dly_start = '0;
    logic          sr_data, sr_clk, sr_latch;

    rail_prog_top #(.NUM_BOARDS(NB), .BITS_PER_BOARD(BPB), .DLY_W(DW)) dut (
        .clk(clk), .rst_n(rst_n), .ctrl_en(ctrl_en), .abort(abort),
        .mask_drv(mask_drv), .mask_all(mask_all), .mask_off(mask_off),
        .dly_start(dly_start), .sr_data(sr_data), .sr_clk(sr_clk),
        .sr_latch(sr_latch)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_err = 0, cyc = 0;
    bit finished = 0;

    // external chain model and observation log
    logic [W-1:0] chain = '0;
    logic [W-1:0] lat_log [8];
    int           bits_log [8];
    int n_lat = 0, rises = 0, lat_cyc = 0, last_gap = -1, bad_pulse = 0;
    bit armed = 0, prev_clk = 0, prev_lat = 0;

    function automatic int exp_gap(int d);
        return d + 6;
    endfunction

    task automatic report();
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc >= 150000 && !finished) begin
            finished = 1;
            n_chk++; n_err++;
            $display("FAIL watchdog: actual=hung expected=finished");
            report();
        end
    end

    always @(negedge clk) begin
        if (rst_n) begin
            if (sr_clk) begin
                chain = {chain[W-2:0], sr_data};
                rises++;
                if (armed) begin last_gap = cyc - lat_cyc; armed = 0; end
                if (prev_clk) bad_pulse++;
            end
            if (sr_latch) begin
                if (n_lat < 8) begin lat_log[n_lat] = chain; bits_log[n_lat] = rises; end
                n_lat++;
                rises = 0;
                lat_cyc = cyc;
                armed = 1;
                if (prev_lat || sr_clk) bad_pulse++;
            end
            prev_clk = sr_clk;
            prev_lat = sr_latch;
        end
    end

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clear_log();
        n_lat = 0; rises = 0; armed = 0; last_gap = -1;
    endtask

    task automatic wait_latches(input int k);
        int guard = 0;
        while (n_lat < k && guard < 2000) begin
            @(negedge clk);
            guard++;
        end
    endtask

    task automatic drive_en(input logic v);
        @(negedge clk);
        ctrl_en = v;
    endtask

    task automatic pulse_abort();
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
    endtask

    initial begin
        void'($urandom(32'd7321));
        settle(4);
        chk("R1 reset sr_clk", 64'(sr_clk), 64'd0);
        chk("R1 reset sr_latch", 64'(sr_latch), 64'd0);
        chk("R1 reset sr_data", 64'(sr_data), 64'd0);
        rst_n = 1'b1;
        settle(20);
        chk("R1 quiet after reset", 64'(n_lat), 64'd0);

        // on/off cycles: directed corners first, then random
        for (int i = 0; i < 8; i++) begin
            int d;
            if (i == 0) begin
                mask_drv = {NB{16'h0008}};
                mask_all = {NB{16'hFFF8}};
                mask_off = {NB{16'h0000}} | W'(1) << (W - 1);
                d = 0;
            end else if (i == 1) begin
                mask_drv = {W{1'b1}};
                mask_all = '0;
                mask_off = {NB{16'hA5C3}};
                d = 63;
            end else begin
                mask_drv = W'($urandom);
                mask_all = W'($urandom);
                mask_off = W'($urandom);
                d = int'($urandom % 64);
            end
            dly_start = DW'(d);
            clear_log();
            drive_en(1'b1);
            settle(300);
            chk("R2 latch count on rise", 64'(n_lat), 64'd2);
            chk("R2 gate-driver mask latched", 64'(lat_log[0]), 64'(mask_drv));
            chk("R10 all-nets mask latched after delay", 64'(lat_log[1]), 64'(mask_all));
            chk("R3 delay spacing", 64'(last_gap), 64'(exp_gap(d)));
            chk("R8 bits per transfer", 64'(bits_log[0]), 64'(W));
            clear_log();
            drive_en(1'b0);
            settle(150);
            chk("R4 single latch on fall", 64'(n_lat), 64'd1);
            chk("R4 off mask latched", 64'(lat_log[0]), 64'(mask_off));
        end

        // R5/R6: fall during delay, then rise while busy
        mask_drv = W'($urandom); mask_all = W'($urandom); mask_off = W'($urandom);
        dly_start = DW'(40);
        clear_log();
        drive_en(1'b1);
        wait_latches(1);
        settle(5);
        drive_en(1'b0);
        settle(3);
        drive_en(1'b1);
        settle(300);
        chk("R6 no extra transfer from busy rise", 64'(n_lat), 64'd2);
        chk("R5 off replaces all-nets after delay fall", 64'(lat_log[1]), 64'(mask_off));
        clear_log();
        drive_en(1'b0);
        settle(150);
        chk("R4 off after ignored rise", 64'(lat_log[0]), 64'(mask_off));

        // R5: fall during the gate-driver transfer
        clear_log();
        drive_en(1'b1);
        settle(20);
        drive_en(1'b0);
        settle(300);
        chk("R5 latch count fall in transfer", 64'(n_lat), 64'd2);
        chk("R5 first is gate-driver mask", 64'(lat_log[0]), 64'(mask_drv));
        chk("R5 second is off mask", 64'(lat_log[1]), 64'(mask_off));

        // R7: abort mid-transfer
        clear_log();
        drive_en(1'b1);
        settle(30);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        chk("R7 clock low after abort", 64'(sr_clk), 64'd0);
        chk("R7 latch low after abort", 64'(sr_latch), 64'd0);
        settle(300);
        chk("R7 no latch for aborted sequence", 64'(n_lat), 64'd0);
        clear_log();
        drive_en(1'b0);
        settle(150);
        chk("R7 off works after abort", 64'(lat_log[0]), 64'(mask_off));

        // R7: abort during delay
        dly_start = DW'(50);
        clear_log();
        drive_en(1'b1);
        wait_latches(1);
        settle(10);
        pulse_abort();
        settle(300);
        chk("R7 abort in delay stops all-nets", 64'(n_lat), 64'd1);
        drive_en(1'b0);
        settle(150);

        chk("R9 R8 pulse widths", 64'(bad_pulse), 64'd0);
        finished = 1;
        report();
    end
endmodule